// File: doc/BRIEF.md
# Multi-Screen Segment Store

This block keeps the on/off bits of the display segments for four independent screens and lets a processor reach them through a small register window. The processor never addresses the storage directly. It loads a byte into a data register, then writes a pointer register. That pointer write starts the transfer. Its top bit picks the direction: storing the held byte, or fetching a stored byte back into the data register. A configuration register holds a freeze flag and a two-bit screen designator. The designator picks both the screen the processor reaches and the screen shown on the display side.

The segment driver reads one byte at a time through a combinational display port. Each byte carries two segment lines, and the port splits it into an even-line nibble and an odd-line nibble. While the freeze flag is set, the display port reads a shadow image of the screen. That image was captured when the freeze took hold, so software can rewrite the store, or switch screens, without the panel showing half-finished content. Segment storage has no reset, so its contents survive a reset of the control registers, as they must across the lowest-power mode.

Top module: `seg_screen_mem`

## Requirements
- R1: After reset the data register reads 0x00, the freeze flag is clear and the screen designator is 0.
- R2: A data write (`data_wr_en`) loads `data_wr_val` into the data register, and the new value is visible on `data_q` after the next rising clock edge.
- R3: A pointer write with bit 7 set stores the byte held in the data register into the location given by pointer bits 6:0 of the designated screen, and leaves the data register unchanged.
- R4: A pointer write with bit 7 clear loads the addressed byte of the designated screen into the data register, and it is visible on `data_q` one clock after the pointer write.
- R5: When a data write and a pointer write fall in the same cycle, a store uses the value the data register held before that cycle and the data register then takes the new value. A fetch takes priority over the data write.
- R6: A pointer address of 15 or more is ignored for stores: no location of any screen changes. A fetch from such an address loads 0x00.
- R7: Configuration bit 0 is the freeze flag and bits 2:1 are the screen designator. The four screens hold independent contents.
- R8: When not frozen, the display port shows the byte of the designated screen at `disp_addr`: the low nibble (even segment line) on `disp_even` and the high nibble (odd segment line) on `disp_odd`. A `disp_addr` of 15 shows zero on both.
- R9: While frozen, the display port shows the screen content captured at the clock edge that set the flag. Stores and screen changes made during the freeze do not appear.
- R10: From the clock edge that clears the freeze flag, the display port shows the current contents of the designated screen.
- R11: Segment contents are retained across reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| data_wr_en | input | 1 | Processor write strobe for the data register |
| data_wr_val | input | 8 | Value for the data register |
| ptr_wr_en | input | 1 | Processor write strobe for the pointer register; starts a transfer |
| ptr_wr_val | input | 8 | Bit 7: 1 store, 0 fetch; bits 6:0: byte address |
| cfg_wr_en | input | 1 | Processor write strobe for the configuration register |
| cfg_wr_val | input | 3 | Bit 0 freeze, bits 2:1 screen designator |
| data_q | output | 8 | Data register contents |
| disp_addr | input | 4 | Byte index requested by the segment driver |
| disp_even | output | 4 | Even segment line bits of the selected byte |
| disp_odd | output | 4 | Odd segment line bits of the selected byte |

## Verification
The bench fires a data write and a pointer write in the same cycle in both directions. A design that sampled the data register too late would store the new byte rather than the held one, and one that let the data write win would lose the fetched byte. It probes pointer addresses 15 and 127, where a missing range check would corrupt a real location or return stale data instead of zero. It freezes the display, then rewrites the store and switches screens, catching a shadow that keeps tracking memory or a mux that ignores the flag. It pulses reset after all this to confirm that a reset which cleared the store would be seen.

// File: rtl/seg_mem_pkg.sv
package seg_mem_pkg;
  localparam int SCREENS    = 4;
  localparam int BANK_BYTES = 15;
  localparam int BYTE_W     = 8;
  localparam int NIB_W      = BYTE_W / 2;
  localparam int SCR_W      = $clog2(SCREENS);
  localparam int AW         = $clog2(BANK_BYTES);
  localparam int PTR_W      = BYTE_W;
  localparam int CFG_W      = 1 + SCR_W;

  typedef logic [BYTE_W-1:0] seg_byte_t;
  typedef logic [SCR_W-1:0]  scr_idx_t;
  typedef logic [AW-1:0]     byte_idx_t;
  typedef logic [BANK_BYTES-1:0][BYTE_W-1:0] screen_img_t;

  typedef struct packed {
    logic      en;
    scr_idx_t  scr;
    byte_idx_t idx;
    seg_byte_t val;
  } mem_wr_t;
endpackage

// File: rtl/seg_access_ctrl.sv
module seg_access_ctrl
  import seg_mem_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             data_wr_en,
  input  seg_byte_t        data_wr_val,
  input  logic             ptr_wr_en,
  input  logic [PTR_W-1:0] ptr_wr_val,
  input  logic             cfg_wr_en,
  input  logic [CFG_W-1:0] cfg_wr_val,
  input  seg_byte_t        rd_byte,
  output byte_idx_t        rd_idx,
  output seg_byte_t        data_q,
  output logic             freeze,
  output scr_idx_t         scr,
  output mem_wr_t          wr
);
  logic             ptr_dir;
  logic [PTR_W-2:0] ptr_addr;
  logic             ptr_ok;
  logic             data_en;
  seg_byte_t        data_d;
  seg_byte_t        data_r;
  logic [CFG_W-1:0] cfg_r;

  assign ptr_dir  = ptr_wr_val[PTR_W-1];
  assign ptr_addr = ptr_wr_val[PTR_W-2:0];
  assign ptr_ok   = ptr_addr < (PTR_W-1)'(BANK_BYTES);
  assign rd_idx   = ptr_addr[AW-1:0];

  // next state of the data register: a fetch outranks a plain data load
  always_comb begin
    data_en = 1'b0;
    data_d  = data_r;
    if (ptr_wr_en && !ptr_dir) begin
      data_en = 1'b1;
      data_d  = ptr_ok ? rd_byte : '0;
    end else if (data_wr_en) begin
      data_en = 1'b1;
      data_d  = data_wr_val;
    end
  end

  // a store carries the byte held before this cycle
  always_comb begin
    wr.en  = ptr_wr_en && ptr_dir && ptr_ok;
    wr.scr = cfg_r[CFG_W-1:1];
    wr.idx = ptr_addr[AW-1:0];
    wr.val = data_r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_r <= '0;
    end else if (data_en) begin
      data_r <= data_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_r <= '0;
    end else if (cfg_wr_en) begin
      cfg_r <= cfg_wr_val;
    end
  end

  assign data_q = data_r;
  assign freeze = cfg_r[0];
  assign scr    = cfg_r[CFG_W-1:1];

  assert_data_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr_en && !(ptr_wr_en && !ptr_dir)) |=> data_q == $past(data_wr_val));

  assert_store_keeps_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_wr_en && ptr_dir && !data_wr_en) |=> $stable(data_q));

  assert_bad_fetch_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_wr_en && !ptr_dir && !ptr_ok) |=> data_q == '0);
endmodule

// File: rtl/seg_bank_store.sv
module seg_bank_store
  import seg_mem_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  mem_wr_t     wr,
  input  scr_idx_t    rd_scr,
  input  byte_idx_t   rd_idx,
  output seg_byte_t   rd_byte,
  input  scr_idx_t    disp_scr,
  output screen_img_t live_img
);
  screen_img_t bank [SCREENS];
  logic        rd_ok;

  // segment storage carries no reset so it outlives a control reset
  always_ff @(posedge clk) begin
    for (int s = 0; s < SCREENS; s++) begin
      if (wr.en && (wr.scr == scr_idx_t'(s))) begin
        bank[s][wr.idx] <= wr.val;
      end
    end
  end

  assign rd_ok    = rd_idx < AW'(BANK_BYTES);
  assign rd_byte  = rd_ok ? bank[rd_scr][rd_idx] : '0;
  assign live_img = bank[disp_scr];

  assert_store_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr.en |=> bank[$past(wr.scr)][$past(wr.idx)] == $past(wr.val));
endmodule

// File: rtl/seg_shadow.sv
module seg_shadow
  import seg_mem_pkg::*;
(
  input  logic        clk,
  input  logic        load,
  input  screen_img_t live_img,
  output screen_img_t shadow_img
);
  for (genvar b = 0; b < BANK_BYTES; b++) begin : g_byte
    seg_byte_t q;
    always_ff @(posedge clk) begin
      if (load) begin
        q <= live_img[b];
      end
    end
    assign shadow_img[b] = q;
  end
endmodule

// File: rtl/seg_screen_mem.sv
module seg_screen_mem
  import seg_mem_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              data_wr_en,
  input  logic [BYTE_W-1:0] data_wr_val,
  input  logic              ptr_wr_en,
  input  logic [PTR_W-1:0]  ptr_wr_val,
  input  logic              cfg_wr_en,
  input  logic [CFG_W-1:0]  cfg_wr_val,
  output logic [BYTE_W-1:0] data_q,
  input  logic [AW-1:0]     disp_addr,
  output logic [NIB_W-1:0]  disp_even,
  output logic [NIB_W-1:0]  disp_odd
);
  logic [1:0]  rst_sync;
  logic        rst_i;
  seg_byte_t   rd_byte;
  byte_idx_t   rd_idx;
  logic        freeze;
  scr_idx_t    scr;
  mem_wr_t     wr;
  screen_img_t live_img;
  screen_img_t shadow_img;
  screen_img_t view_img;
  logic        disp_ok;
  seg_byte_t   disp_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= 2'b00;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end
  assign rst_i = rst_sync[1];

  seg_access_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_i),
    .data_wr_en(data_wr_en), .data_wr_val(data_wr_val),
    .ptr_wr_en(ptr_wr_en), .ptr_wr_val(ptr_wr_val),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_val(cfg_wr_val),
    .rd_byte(rd_byte), .rd_idx(rd_idx),
    .data_q(data_q), .freeze(freeze), .scr(scr), .wr(wr)
  );

  seg_bank_store u_store (
    .clk(clk), .rst_n(rst_i), .wr(wr),
    .rd_scr(scr), .rd_idx(rd_idx), .rd_byte(rd_byte),
    .disp_scr(scr), .live_img(live_img)
  );

  // shadow follows the live screen every unfrozen cycle
  seg_shadow u_shadow (
    .clk(clk), .load(!freeze),
    .live_img(live_img), .shadow_img(shadow_img)
  );

  assign view_img  = freeze ? shadow_img : live_img;
  assign disp_ok   = disp_addr < AW'(BANK_BYTES);
  assign disp_byte = disp_ok ? view_img[disp_addr] : '0;
  assign disp_even = disp_byte[NIB_W-1:0];
  assign disp_odd  = disp_byte[BYTE_W-1:NIB_W];

  assert_frozen_view_R9: assert property (@(posedge clk) disable iff (!rst_i)
    (freeze && $past(freeze) && $stable(disp_addr)) |-> $stable(disp_byte));

  assert_live_view_R10: assert property (@(posedge clk) disable iff (!rst_i)
    (!freeze && disp_ok) |-> disp_byte == live_img[disp_addr]);
endmodule

// File: tb/sim_seg_screen_mem.sv
module sim_seg_screen_mem;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       data_wr_en, ptr_wr_en, cfg_wr_en;
  logic [7:0] data_wr_val, ptr_wr_val;
  logic [2:0] cfg_wr_val;
  logic [7:0] data_q;
  logic [3:0] disp_addr;
  logic [3:0] disp_even, disp_odd;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] model [4][15];
  logic [1:0] cur_scr;
  logic       cur_frz;

  always #10 clk = ~clk;

  seg_screen_mem u0 (
    .clk(clk), .rst_n(rst_n),
    .data_wr_en(data_wr_en), .data_wr_val(data_wr_val),
    .ptr_wr_en(ptr_wr_en), .ptr_wr_val(ptr_wr_val),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_val(cfg_wr_val),
    .data_q(data_q), .disp_addr(disp_addr),
    .disp_even(disp_even), .disp_odd(disp_odd)
  );

  function automatic logic [7:0] pat(int s, int a);
    return 8'((a * 17 + s * 64 + 3) & 255);
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cpu_data(logic [7:0] v);
    @(negedge clk); data_wr_en = 1'b1; data_wr_val = v;
    @(negedge clk); data_wr_en = 1'b0;
  endtask

  task automatic cpu_ptr(logic [7:0] v);
    @(negedge clk); ptr_wr_en = 1'b1; ptr_wr_val = v;
    @(negedge clk); ptr_wr_en = 1'b0;
  endtask

  task automatic set_cfg(logic frz, logic [1:0] s);
    @(negedge clk); cfg_wr_en = 1'b1; cfg_wr_val = {s, frz};
    @(negedge clk); cfg_wr_en = 1'b0;
    cur_frz = frz; cur_scr = s;
  endtask

  task automatic mem_store(int a, logic [7:0] v);
    cpu_data(v);
    cpu_ptr(8'h80 | 8'(a));
    if (a < 15) model[cur_scr][a] = v;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    cur_frz = 1'b0; cur_scr = 2'd0;
  endtask

  task automatic t_reset();
    chk("R1 data reg after reset", data_q, 8'h00);
    mem_store(3, 8'hA5);
    disp_addr = 4'd3;
    #1;
    chk("R1 unfrozen screen0 shown", {disp_odd, disp_even}, 8'hA5);
  endtask

  task automatic t_fill();
    for (int s = 0; s < 4; s++) begin
      set_cfg(1'b0, 2'(s));
      for (int a = 0; a < 15; a++) mem_store(a, pat(s, a));
    end
    set_cfg(1'b0, 2'd0);
  endtask

  task automatic t_data_reg();
    cpu_data(8'h3C);
    chk("R2 data load", data_q, 8'h3C);
    cpu_data(8'hC3);
    chk("R2 data reload", data_q, 8'hC3);
  endtask

  task automatic t_readback();
    for (int a = 0; a < 15; a++) begin
      cpu_ptr(8'(a));
      chk("R4 fetch screen0", data_q, model[0][a]);
    end
    cpu_data(8'h6E);
    cpu_ptr(8'h80 | 8'd9);
    model[0][9] = 8'h6E;
    chk("R3 data kept after store", data_q, 8'h6E);
    cpu_ptr(8'd9);
    chk("R3 store then fetch", data_q, 8'h6E);
  endtask

  task automatic t_screens();
    for (int s = 0; s < 4; s++) begin
      set_cfg(1'b0, 2'(s));
      cpu_ptr(8'd5);
      chk("R7 per-screen byte5", data_q, model[s][5]);
      cpu_ptr(8'd14);
      chk("R7 per-screen byte14", data_q, model[s][14]);
    end
    set_cfg(1'b0, 2'd0);
  endtask

  task automatic t_same_cycle();
    cpu_data(8'h11);
    @(negedge clk);
    data_wr_en = 1'b1; data_wr_val = 8'h22;
    ptr_wr_en = 1'b1; ptr_wr_val = 8'h86;
    @(negedge clk);
    data_wr_en = 1'b0; ptr_wr_en = 1'b0;
    model[0][6] = 8'h11;
    chk("R5 data takes new value", data_q, 8'h22);
    cpu_ptr(8'd6);
    chk("R5 store used held value", data_q, 8'h11);
    cpu_data(8'h44);
    @(negedge clk);
    data_wr_en = 1'b1; data_wr_val = 8'h33;
    ptr_wr_en = 1'b1; ptr_wr_val = 8'h06;
    @(negedge clk);
    data_wr_en = 1'b0; ptr_wr_en = 1'b0;
    chk("R5 fetch wins over data write", data_q, 8'h11);
  endtask

  task automatic t_range();
    cpu_data(8'hEE);
    cpu_ptr(8'h8F);
    cpu_ptr(8'hFF);
    for (int a = 0; a < 15; a++) begin
      cpu_ptr(8'(a));
      chk("R6 bad store left bytes", data_q, model[0][a]);
    end
    cpu_data(8'h5A);
    cpu_ptr(8'h0F);
    chk("R6 fetch addr15 zero", data_q, 8'h00);
    cpu_data(8'h5A);
    cpu_ptr(8'h7F);
    chk("R6 fetch addr127 zero", data_q, 8'h00);
  endtask

  task automatic t_display();
    for (int a = 0; a < 15; a++) begin
      disp_addr = 4'(a);
      #1;
      chk("R8 even nibble", {4'h0, disp_even}, {4'h0, model[0][a][3:0]});
      chk("R8 odd nibble", {4'h0, disp_odd}, {4'h0, model[0][a][7:4]});
    end
    disp_addr = 4'd15;
    #1;
    chk("R8 addr15 blank", {disp_odd, disp_even}, 8'h00);
    set_cfg(1'b0, 2'd2);
    disp_addr = 4'd5;
    #1;
    chk("R8 screen2 shown", {disp_odd, disp_even}, model[2][5]);
    set_cfg(1'b0, 2'd0);
  endtask

  task automatic t_freeze();
    disp_addr = 4'd4;
    #1;
    chk("R9 before freeze", {disp_odd, disp_even}, model[0][4]);
    set_cfg(1'b1, 2'd0);
    mem_store(4, 8'h99);
    #1;
    chk("R9 store hidden", {disp_odd, disp_even}, pat(0, 4));
    set_cfg(1'b1, 2'd1);
    #1;
    chk("R9 screen change hidden", {disp_odd, disp_even}, pat(0, 4));
  endtask

  task automatic t_unfreeze();
    set_cfg(1'b0, 2'd0);
    #1;
    chk("R10 new content shown", {disp_odd, disp_even}, 8'h99);
    set_cfg(1'b0, 2'd1);
    #1;
    chk("R10 screen1 shown", {disp_odd, disp_even}, model[1][4]);
  endtask

  task automatic t_retain();
    do_reset();
    chk("R1 data reg after second reset", data_q, 8'h00);
    cpu_ptr(8'd4);
    chk("R11 screen0 kept", data_q, 8'h99);
    set_cfg(1'b0, 2'd3);
    cpu_ptr(8'd11);
    chk("R11 screen3 kept", data_q, model[3][11]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog all-requirements actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    data_wr_en = 1'b0; ptr_wr_en = 1'b0; cfg_wr_en = 1'b0;
    data_wr_val = '0; ptr_wr_val = '0; cfg_wr_val = '0;
    disp_addr = '0;
    do_reset();
    t_reset();
    t_fill();
    t_data_reg();
    t_readback();
    t_screens();
    t_same_cycle();
    t_range();
    t_display();
    t_freeze();
    t_unfreeze();
    t_retain();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule